// File: doc/BRIEF.md
# UART Interrupt Control and Status Registers

This block gathers the interrupt-worthy conditions of a UART into one request line. It sits on a small 32-bit register bus with byte addresses. It holds a set of sticky event flags and an enable mask for those flags.

The mask cannot be written directly. Software turns bits on through a set-only port and turns them off through a clear-only port. Flags are acknowledged by writing ones to them.

Flag 0 comes from a comparison between the receive FIFO occupancy and a programmable trigger level. The remaining flags take external event inputs, such as line errors and transmit FIFO conditions. A separate channel status register reports live conditions that follow the hardware and need no clearing.

A typical driver programs the trigger level, unmasks flag 0, and waits for the interrupt. It then drains the FIFO below the level and writes the read status value back to acknowledge.

Top module: `uart_irq_regs`

## Requirements
- R1: After reset the status, mask and trigger level are all zero and `irq_o` is low.
- R2: A status flag, once set, stays set after its condition goes away, until software clears it.
- R3: A write to offset 0x14 clears each status bit whose write-data bit is 1. Bits written 0 keep their value. Reading 0x14 returns the status in bits [NUM_EVT-1:0].
- R4: The mask reads back at offset 0x10. A write to 0x10 leaves the mask unchanged.
- R5: Writing offset 0x08 sets every mask bit whose data bit is 1. Writing offset 0x0C clears every mask bit whose data bit is 1. Zero data bits change nothing. Both offsets read as 0.
- R6: `irq_o` is high exactly when some bit is set in both the mask and the status.
- R7: Status bit 0 sets on the clock edge at which the receive count is greater than or equal to a nonzero trigger level.
- R8: The trigger level is written at offset 0x20 from data bits [5:0] and read back there, with the upper bits reading 0. A level of 0 never sets status bit 0.
- R9: When a write-1-to-clear at 0x14 meets a condition that sets the same flag in the same cycle, the flag stays set.
- R10: Offset 0x2C shows live, non-sticky conditions: bit 0 = receive count is 0, bit 1 = receive count equals FIFO depth, bit 2 = the trigger comparison of R7 holds now, bits [2+LIVE_W:3] = `live_i`.
- R11: Each `evt_i[k]` that is high at a clock edge sets status bit k+1.
- R12: Unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW (6) | Byte offset for read and write |
| reg_wdata_i | input | DW (32) | Write data |
| reg_rdata_o | output | DW (32) | Read data for `reg_addr_i`, combinational |
| rx_count_i | input | CNT_W (7) | Receive FIFO occupancy |
| evt_i | input | NUM_EVT-1 (7) | External event conditions for status bits 1 and up |
| live_i | input | LIVE_W (2) | Live conditions shown in channel status |
| irq_o | output | 1 | Interrupt request |

## Verification
Two functions can act on one status bit in the same cycle: a write-1-to-clear at 0x14 and a set from the trigger comparison or from an event input. The bench provokes this directly. It writes ones to status while the receive count sits at or above the level, and again while event inputs are high. A random phase also mixes status writes with live events. Each case is judged by the status readback and `irq_o` on the following cycle, which must show the flag still set.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
    localparam int unsigned OFF_IER  = 'h08;
    localparam int unsigned OFF_IDR  = 'h0C;
    localparam int unsigned OFF_MSK  = 'h10;
    localparam int unsigned OFF_STS  = 'h14;
    localparam int unsigned OFF_TRG  = 'h20;
    localparam int unsigned OFF_CHAN = 'h2C;
endpackage

// File: rtl/uirq_wr_dec.sv
module uirq_wr_dec
    import uirq_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    output logic          ier_we_o,
    output logic          idr_we_o,
    output logic          sts_we_o,
    output logic          trg_we_o
);
    always_comb begin
        ier_we_o = we_i && (addr_i == AW'(OFF_IER));
        idr_we_o = we_i && (addr_i == AW'(OFF_IDR));
        sts_we_o = we_i && (addr_i == AW'(OFF_STS));
        trg_we_o = we_i && (addr_i == AW'(OFF_TRG));
    end
endmodule

// File: rtl/uirq_rx_trig.sv
module uirq_rx_trig #(
    parameter int CNT_W      = 7,
    parameter int TRIG_W     = 6,
    parameter int FIFO_DEPTH = 64
) (
    input  logic [CNT_W-1:0]  count_i,
    input  logic [TRIG_W-1:0] level_i,
    output logic              hit_o,
    output logic              empty_o,
    output logic              full_o
);
    always_comb begin
        hit_o   = (level_i != '0) && (32'(count_i) >= 32'(level_i));
        empty_o = (count_i == '0);
        full_o  = (32'(count_i) == 32'(FIFO_DEPTH));
    end
endmodule

// File: rtl/uirq_rd_mux.sv
module uirq_rd_mux
    import uirq_pkg::*;
#(
    parameter int AW      = 6,
    parameter int DW      = 32,
    parameter int NUM_EVT = 8,
    parameter int TRIG_W  = 6,
    parameter int CHAN_W  = 5
) (
    input  logic [AW-1:0]      addr_i,
    input  logic [NUM_EVT-1:0] sts_i,
    input  logic [NUM_EVT-1:0] msk_i,
    input  logic [TRIG_W-1:0]  trig_i,
    input  logic [CHAN_W-1:0]  chan_i,
    output logic [DW-1:0]      rdata_o
);
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            AW'(OFF_STS):  rdata_o[NUM_EVT-1:0] = sts_i;
            AW'(OFF_MSK):  rdata_o[NUM_EVT-1:0] = msk_i;
            AW'(OFF_TRG):  rdata_o[TRIG_W-1:0]  = trig_i;
            AW'(OFF_CHAN): rdata_o[CHAN_W-1:0]  = chan_i;
            default:       rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
    import uirq_pkg::*;
#(
    parameter int NUM_EVT    = 8,
    parameter int FIFO_DEPTH = 64,
    parameter int TRIG_W     = 6,
    parameter int LIVE_W     = 2,
    parameter int AW         = 6,
    parameter int DW         = 32,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               reg_we_i,
    input  logic [AW-1:0]      reg_addr_i,
    input  logic [DW-1:0]      reg_wdata_i,
    output logic [DW-1:0]      reg_rdata_o,
    input  logic [CNT_W-1:0]   rx_count_i,
    input  logic [NUM_EVT-2:0] evt_i,
    input  logic [LIVE_W-1:0]  live_i,
    output logic               irq_o
);
    localparam int CHAN_W = 3 + LIVE_W;

    typedef struct packed {
        logic [NUM_EVT-1:0] sts;
        logic [NUM_EVT-1:0] msk;
        logic [TRIG_W-1:0]  trig;
    } state_t;

    state_t st_d, st_q;

    logic ier_we, idr_we, sts_we, trg_we;
    logic rx_hit, rx_empty, rx_full;
    logic [NUM_EVT-1:0] clr_vec, set_vec;
    logic [NUM_EVT-1:0] sts_q, msk_q;
    logic [TRIG_W-1:0]  trig_q;
    logic [CHAN_W-1:0]  chan;
    logic [DW-1:0]      unused_wdata;

    assign unused_wdata = reg_wdata_i;
    assign sts_q  = st_q.sts;
    assign msk_q  = st_q.msk;
    assign trig_q = st_q.trig;

    uirq_wr_dec #(.AW(AW)) u_dec (
        .we_i     (reg_we_i),
        .addr_i   (reg_addr_i),
        .ier_we_o (ier_we),
        .idr_we_o (idr_we),
        .sts_we_o (sts_we),
        .trg_we_o (trg_we)
    );

    uirq_rx_trig #(.CNT_W(CNT_W), .TRIG_W(TRIG_W), .FIFO_DEPTH(FIFO_DEPTH)) u_trig (
        .count_i (rx_count_i),
        .level_i (trig_q),
        .hit_o   (rx_hit),
        .empty_o (rx_empty),
        .full_o  (rx_full)
    );

    assign chan = {live_i, rx_hit, rx_full, rx_empty};

    uirq_rd_mux #(
        .AW(AW), .DW(DW), .NUM_EVT(NUM_EVT), .TRIG_W(TRIG_W), .CHAN_W(CHAN_W)
    ) u_rd (
        .addr_i  (reg_addr_i),
        .sts_i   (sts_q),
        .msk_i   (msk_q),
        .trig_i  (trig_q),
        .chan_i  (chan),
        .rdata_o (reg_rdata_o)
    );

    always_comb begin
        st_d    = st_q;
        clr_vec = sts_we ? reg_wdata_i[NUM_EVT-1:0] : '0;
        set_vec = {evt_i, rx_hit};
        if (ier_we) st_d.msk = st_q.msk | reg_wdata_i[NUM_EVT-1:0];
        if (idr_we) st_d.msk = st_q.msk & ~reg_wdata_i[NUM_EVT-1:0];
        if (trg_we) st_d.trig = reg_wdata_i[TRIG_W-1:0];
        st_d.sts = (st_q.sts & ~clr_vec) | set_vec;
        irq_o    = |(st_q.msk & st_q.sts);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/uirq_checker.sv
module uirq_checker
    import uirq_pkg::*;
#(
    parameter int NUM_EVT = 8,
    parameter int TRIG_W  = 6,
    parameter int AW      = 6,
    parameter int DW      = 32,
    parameter int CNT_W   = 7
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               we_i,
    input logic [AW-1:0]      addr_i,
    input logic [DW-1:0]      wdata_i,
    input logic [CNT_W-1:0]   cnt_i,
    input logic               irq_i,
    input logic [NUM_EVT-1:0] sts_i,
    input logic [NUM_EVT-1:0] msk_i,
    input logic [TRIG_W-1:0]  trig_i
);
    assert_enable_sets_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(we_i && addr_i == AW'(OFF_IER)) |->
            ((msk_i & $past(wdata_i[NUM_EVT-1:0])) == $past(wdata_i[NUM_EVT-1:0])));

    assert_disable_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(we_i && addr_i == AW'(OFF_IDR)) |->
            ((msk_i & $past(wdata_i[NUM_EVT-1:0])) == '0));

    assert_mask_readonly_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(we_i && addr_i == AW'(OFF_MSK)) |-> $stable(msk_i));

    assert_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(we_i && addr_i == AW'(OFF_STS)) |-> (($past(sts_i) & ~sts_i) == '0));

    assert_irq_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(irq_i) && !$past(we_i)) |-> irq_i);

    assert_trig_sets_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(trig_i != '0 && 32'(cnt_i) >= 32'(trig_i)) |-> sts_i[0]);

    assert_zero_level_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(trig_i == '0) && !$past(sts_i[0])) |-> !sts_i[0]);
endmodule

bind uart_irq_regs uirq_checker #(
    .NUM_EVT(NUM_EVT), .TRIG_W(TRIG_W), .AW(AW), .DW(DW), .CNT_W(CNT_W)
) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .cnt_i   (rx_count_i),
    .irq_i   (irq_o),
    .sts_i   (sts_q),
    .msk_i   (msk_q),
    .trig_i  (trig_q)
);

// File: tb/sim_uart_irq_regs.sv
`timescale 1ns/1ps
module sim_uart_irq_regs;
    localparam int NEV = 8;
    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [5:0]  addr = 6'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [6:0]  cnt = '0;
    logic [6:0]  evt = '0;
    logic [1:0]  live = '0;
    logic        irq;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 0;
    string req = "R1";

    // reference model state
    logic [7:0] m_sts = '0, m_msk = '0;
    logic [5:0] m_trig = '0;

    always #10 clk = ~clk;

    uart_irq_regs u0 (
        .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .rx_count_i(cnt),
        .evt_i(evt), .live_i(live), .irq_o(irq)
    );

    function automatic logic trig_hit();
        return (m_trig != 0) && (int'(cnt) >= int'(m_trig));
    endfunction

    function automatic logic [31:0] exp_rd();
        logic [31:0] r = '0;
        case (addr)
            6'h14: r[7:0] = m_sts;
            6'h10: r[7:0] = m_msk;
            6'h20: r[5:0] = m_trig;
            6'h2C: r[4:0] = {live, trig_hit(), int'(cnt) == DEPTH, cnt == 0};
            default: r = '0;
        endcase
        return r;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sts = '0; m_msk = '0; m_trig = '0;
        end else begin
            logic [7:0] clr, set;
            clr = (we && addr == 6'h14) ? wdata[7:0] : 8'h00;
            set = {evt, trig_hit()};
            m_sts = (m_sts & ~clr) | set;
            if (we && addr == 6'h08) m_msk = m_msk | wdata[7:0];
            if (we && addr == 6'h0C) m_msk = m_msk & ~wdata[7:0];
            if (we && addr == 6'h20) m_trig = wdata[5:0];
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (!done) begin
            logic exp_irq;
            exp_irq = |(m_sts & m_msk);
            n_chk++;
            if (rdata !== exp_rd()) begin
                n_bad++;
                $display("FAIL %s rdata addr=%h got=%h exp=%h", req, addr, rdata, exp_rd());
            end
            n_chk++;
            if (irq !== exp_irq) begin
                n_bad++;
                $display("FAIL %s irq got=%b exp=%b", req, irq, exp_irq);
            end
        end
    end

    task automatic step(input logic w, input logic [5:0] a, input logic [31:0] d,
                        input logic [6:0] c, input logic [6:0] e, input logic [1:0] l);
        @(posedge clk); #5;
        we = w; addr = a; wdata = d; cnt = c; evt = e; live = l;
    endtask

    task automatic rd(input logic [5:0] a);
        step(1'b0, a, 32'h0, cnt, 7'h00, live);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state observed at several offsets while in reset
        req = "R1";
        repeat (2) @(posedge clk);
        #5 addr = 6'h14; #10;
        addr = 6'h10; #20;
        addr = 6'h20; #20;
        rst_n = 1'b1;
        rd(6'h14); rd(6'h10);
        // R12: unmapped offsets
        req = "R12"; rd(6'h04); rd(6'h3C);
        // R8: level write/readback, upper bits masked
        req = "R8";
        step(1, 6'h20, 32'hFFFF_FFC5, 0, 0, 0); rd(6'h20);
        // R7: threshold compare at 4
        req = "R7";
        step(1, 6'h20, 32'd4, 0, 0, 0);
        step(0, 6'h14, 0, 3, 0, 0); rd(6'h14);
        step(0, 6'h14, 0, 4, 0, 0); rd(6'h14);
        // R2: condition removed, flag holds
        req = "R2";
        step(0, 6'h14, 0, 0, 0, 0); rd(6'h14); rd(6'h14);
        // R3: zeros keep, ones clear
        req = "R3";
        step(1, 6'h14, 32'h0, 0, 0, 0); rd(6'h14);
        step(1, 6'h14, 32'h1, 0, 0, 0); rd(6'h14);
        // R9: clear collides with live set
        req = "R9";
        step(1, 6'h14, 32'hFF, 5, 0, 0); rd(6'h14);
        step(1, 6'h14, 32'h06, 0, 7'h03, 0); rd(6'h14);
        // R11: external events map to bits 1..7
        req = "R11";
        step(0, 6'h14, 0, 0, 7'h40, 0); step(0, 6'h14, 0, 0, 7'h15, 0); rd(6'h14);
        // R5: enable / disable
        req = "R5";
        step(1, 6'h08, 32'h05, 0, 0, 0); rd(6'h10);
        step(1, 6'h08, 32'h00, 0, 0, 0); rd(6'h08);
        step(1, 6'h0C, 32'h04, 0, 0, 0); rd(6'h10); rd(6'h0C);
        step(1, 6'h0C, 32'h00, 0, 0, 0); rd(6'h10);
        // R4: mask is read-only at its own offset
        req = "R4";
        step(1, 6'h10, 32'hFF, 0, 0, 0); rd(6'h10);
        step(1, 6'h10, 32'h00, 0, 0, 0); rd(6'h10);
        // R6: irq follows mask & status
        req = "R6";
        step(1, 6'h14, 32'hFF, 0, 0, 0); rd(6'h14);
        step(0, 6'h14, 0, 0, 7'h02, 0); rd(6'h14);
        step(1, 6'h08, 32'h08, 0, 0, 0); rd(6'h14);
        step(1, 6'h0C, 32'h08, 0, 0, 0); rd(6'h14);
        step(1, 6'h08, 32'h01, 6, 0, 0); rd(6'h14);
        step(1, 6'h14, 32'h01, 0, 0, 0); rd(6'h14);
        // R8: zero level never triggers
        req = "R8";
        step(1, 6'h20, 32'h0, 0, 0, 0);
        step(1, 6'h14, 32'hFF, 64, 0, 0); rd(6'h14); rd(6'h14);
        // R10: live channel status
        req = "R10";
        rd(6'h2C);
        step(0, 6'h2C, 0, 0, 0, 2'b10); rd(6'h2C);
        step(1, 6'h20, 32'd2, 1, 0, 2'b01); rd(6'h2C);
        step(0, 6'h2C, 0, 2, 0, 0); step(0, 6'h2C, 0, 0, 0, 0); rd(6'h2C);
        // mixed phase: collisions of clears with sets
        req = "R9";
        for (int i = 0; i < 400; i++) begin
            logic [5:0] a;
            case ($urandom_range(0, 6))
                0: a = 6'h08; 1: a = 6'h0C; 2: a = 6'h10; 3: a = 6'h14;
                4: a = 6'h20; 5: a = 6'h2C; default: a = 6'h18;
            endcase
            step(($urandom_range(0, 2) == 0), a, $urandom,
                 7'($urandom_range(0, 64)), 7'($urandom & $urandom), 2'($urandom));
        end
        step(0, 6'h14, 0, 0, 0, 0);
        repeat (2) @(posedge clk);
        #15;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule